// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block sits between a register port and a delta-sigma conversion engine and decides when conversions run. It has two modes. In continuous mode the engine is restarted the cycle after every result. In single-shot mode the block stays powered down until software writes a one to the start/status bit of the configuration register. That bit then reads zero until the result has been stored. After that the block powers down again.

Each raw engine sample is a 16-bit signed value. The block clamps it into the 12-bit two's-complement range and stores it in the upper twelve bits of the 16-bit result register. The low four bits of the result are always zero. A general-call reset strobe restores the same state as the power-up reset. Reads are combinational. Writes take effect at the clock edge.

Top module: `adc_conv_seq`

## Requirements
- R1: A stored result holds the clamped 12-bit code in bits 15:4 and zeros in bits 3:0. Raw 0 reads 0x0000, raw +1 reads 0x0010, raw -1 reads 0xFFF0, raw +100 reads 0x0640 and raw -100 reads 0xF9C0.
- R2: Raw samples at or above +2047 read 0x7FF0, and raw samples at or below -2048 read 0x8000. The code saturates and never wraps.
- R3: After power-up reset the configuration register (address 1) reads 0x8583. In that value, bit 15 (start/status) is 1 and bit 8 (mode, 1 = single-shot, 0 = continuous) is 1. The result register (address 0) reads 0x0000, pwr_down is 1 and eng_start is 0.
- R4: In single-shot mode and while idle, a write to address 1 with bits 15 and 8 both set does three things in the cycle after the write edge: eng_start is 1, bit 15 reads 0 and pwr_down is 0.
- R5: In single-shot mode, an eng_done pulse during a conversion stores the result. In the cycle after that edge, bit 15 reads 1 and pwr_down is 1.
- R6: A write with bit 15 set during a conversion produces no extra eng_start. Bit 15 keeps reading 0.
- R7: When bit 8 is 0 and the block is idle, eng_start pulses one cycle after the mode is written. Each eng_done stores the result, and eng_start pulses again in the next cycle.
- R8: Clearing continuous mode (writing bit 8 = 1) during a conversion lets that conversion finish and store its result. The block then powers down without issuing another start.
- R9: A one-cycle gc_reset pulse returns the configuration register, the result register and the power state to their power-up values.
- R10: An eng_done pulse while the block is idle leaves the result register unchanged.
- R11: eng_start is high for one cycle at a time, and only while pwr_down is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| gc_reset | input | 1 | General-call reset strobe, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 result, 1 configuration) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| eng_start | output | 1 | One-cycle conversion start to the engine |
| eng_done | input | 1 | Engine result valid pulse |
| eng_sample | input | 16 | Raw signed engine sample |
| pwr_down | output | 1 | High while no conversion is in progress |

## Verification
The bench builds the block with its default widths: a 16-bit raw sample, a 12-bit code and a 16-bit register. This makes the full raw range reachable, from -32768 to +32767. The clamp can therefore be driven one count past each rail and out to the extreme values, not only to the exact rail codes. With the default reset word, single-shot idle is the starting point, so the bench reaches continuous mode, mid-conversion mode changes and the general-call reset through ordinary register writes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_CONV = 0;
  localparam int ADDR_CFG  = 1;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 12,
  parameter int REG_W    = 16
) (
  input  logic [SAMPLE_W-1:0] raw,
  output logic [REG_W-1:0]    code,
  output logic                clip_hi,
  output logic                clip_lo
);
  localparam int SHIFT = REG_W - CODE_W;
  localparam logic signed [SAMPLE_W-1:0] TOP = SAMPLE_W'((2 ** (CODE_W - 1)) - 1);
  localparam logic signed [SAMPLE_W-1:0] BOT = SAMPLE_W'(-(2 ** (CODE_W - 1)));

  function automatic logic [REG_W-1:0] justify(input logic signed [SAMPLE_W-1:0] s);
    logic signed [SAMPLE_W-1:0] c;
    if (s > TOP)      c = TOP;
    else if (s < BOT) c = BOT;
    else              c = s;
    return {c[CODE_W-1:0], {SHIFT{1'b0}}};
  endfunction

  logic signed [SAMPLE_W-1:0] s_raw;

  always_comb begin
    s_raw   = $signed(raw);
    clip_hi = (s_raw > TOP);
    clip_lo = (s_raw < BOT);
    code    = justify(s_raw);
  end
endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg #(
  parameter int               REG_W    = 16,
  parameter int               ADDR_W   = 2,
  parameter int               MODE_BIT = 8,
  parameter logic [REG_W-1:0] CFG_DEF  = 16'h8583
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-2:0]  cfg_bits,
  output logic              mode_single,
  output logic              os_write,
  output logic              single_req
);
  import adc_seq_pkg::*;
  localparam int OS_BIT = REG_W - 1;

  logic             cfg_hit;
  logic [REG_W-2:0] cfg_q;

  always_comb begin
    cfg_hit    = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
    os_write   = cfg_hit && wr_data[OS_BIT];
    single_req = os_write && wr_data[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= CFG_DEF[REG_W-2:0];
    else if (gc_reset) cfg_q <= CFG_DEF[REG_W-2:0];
    else if (cfg_hit)  cfg_q <= wr_data[REG_W-2:0];
  end

  assign cfg_bits    = cfg_q;
  assign mode_single = cfg_q[MODE_BIT];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic gc_reset,
  input  logic single_req,
  input  logic mode_single,
  input  logic eng_done,
  output logic busy,
  output logic eng_start,
  output logic done_accept
);
  import adc_seq_pkg::*;

  seq_state_e st_q, st_d;
  logic       launch;
  logic       start_q;

  always_comb begin
    done_accept = (st_q == SEQ_CONV) && eng_done;
    launch      = 1'b0;
    st_d        = st_q;
    case (st_q)
      SEQ_IDLE: begin
        if (single_req || !mode_single) begin
          launch = 1'b1;
          st_d   = SEQ_CONV;
        end
      end
      SEQ_CONV: begin
        if (done_accept) begin
          if (mode_single) st_d = SEQ_IDLE;
          else             launch = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      start_q <= 1'b0;
    end else if (gc_reset) begin
      st_q    <= SEQ_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= launch;
    end
  end

  assign busy      = (st_q == SEQ_CONV);
  assign eng_start = start_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int               SAMPLE_W = 16,
  parameter int               CODE_W   = 12,
  parameter int               REG_W    = 16,
  parameter int               ADDR_W   = 2,
  parameter int               MODE_BIT = 8,
  parameter logic [REG_W-1:0] CFG_DEF  = 16'h8583
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gc_reset,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic                eng_start,
  input  logic                eng_done,
  input  logic [SAMPLE_W-1:0] eng_sample,
  output logic                pwr_down
);
  import adc_seq_pkg::*;

  logic [REG_W-2:0] cfg_bits;
  logic             mode_single;
  logic             os_write;
  logic             single_req;
  logic             busy;
  logic             done_accept;
  logic [REG_W-1:0] fmt_code;
  logic             clip_hi;
  logic             clip_lo;
  logic [REG_W-1:0] conv_q;

  adc_cfg_reg #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .MODE_BIT(MODE_BIT), .CFG_DEF(CFG_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_bits(cfg_bits), .mode_single(mode_single),
    .os_write(os_write), .single_req(single_req)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .single_req(single_req), .mode_single(mode_single),
    .eng_done(eng_done), .busy(busy),
    .eng_start(eng_start), .done_accept(done_accept)
  );

  adc_code_fmt #(
    .SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .REG_W(REG_W)
  ) u_fmt (
    .raw(eng_sample), .code(fmt_code), .clip_hi(clip_hi), .clip_lo(clip_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           conv_q <= '0;
    else if (gc_reset)    conv_q <= '0;
    else if (done_accept) conv_q <= fmt_code;
  end

  always_comb begin
    if (rd_addr == ADDR_W'(ADDR_CFG))       rd_data = {~busy, cfg_bits};
    else if (rd_addr == ADDR_W'(ADDR_CONV)) rd_data = conv_q;
    else                                    rd_data = '0;
  end

  assign pwr_down = ~busy;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int REG_W = 16,
  parameter int SHIFT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gc_reset,
  input logic             eng_start,
  input logic             eng_done,
  input logic             pwr_down,
  input logic             done_accept,
  input logic             mode_single,
  input logic             os_write,
  input logic             clip_hi,
  input logic             clip_lo,
  input logic [REG_W-1:0] conv_q
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R11
  AST_START_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !pwr_down); // R11
  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && !gc_reset) |=> (conv_q[SHIFT-1:0] == '0)); // R1
  AST_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && clip_hi && !gc_reset) |=> (conv_q == {1'b0, {(REG_W-SHIFT-1){1'b1}}, {SHIFT{1'b0}}})); // R2
  AST_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && clip_lo && !gc_reset) |=> (conv_q == {1'b1, {(REG_W-1){1'b0}}})); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_accept && !gc_reset) |=> $stable(conv_q)); // R10
  AST_SINGLE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && mode_single && !gc_reset) |=> pwr_down); // R5
  AST_CONT_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_accept && !mode_single && !gc_reset) |=> eng_start); // R7
  AST_OS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && os_write && !eng_done && !gc_reset) |=> !eng_start); // R6
  AST_GC_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (pwr_down && conv_q == '0)); // R9
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.REG_W(REG_W), .SHIFT(REG_W - CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
  .eng_start(eng_start), .eng_done(eng_done), .pwr_down(pwr_down),
  .done_accept(done_accept), .mode_single(mode_single), .os_write(os_write),
  .clip_hi(clip_hi), .clip_lo(clip_lo), .conv_q(conv_q)
);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gc_reset = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        eng_start;
  logic        eng_done = 1'b0;
  logic [15:0] eng_sample = '0;
  logic        pwr_down;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_start(eng_start), .eng_done(eng_done), .eng_sample(eng_sample),
    .pwr_down(pwr_down)
  );

  // {saturating, raw sample, expected result}
  localparam logic [32:0] VEC [11] = '{
    {1'b0, 16'h0000, 16'h0000},
    {1'b0, 16'h0001, 16'h0010},
    {1'b0, 16'hFFFF, 16'hFFF0},
    {1'b0, 16'h0064, 16'h0640},
    {1'b0, 16'hFF9C, 16'hF9C0},
    {1'b1, 16'h07FF, 16'h7FF0},
    {1'b1, 16'h0800, 16'h7FF0},
    {1'b1, 16'h7FFF, 16'h7FF0},
    {1'b1, 16'hF800, 16'h8000},
    {1'b1, 16'hF7FF, 16'h8000},
    {1'b1, 16'h8000, 16'h8000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic done_pulse(input logic [15:0] s);
    @(negedge clk);
    eng_done = 1'b1; eng_sample = s;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x0000 expected=0x0001");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    rd(2'd1, v); check("R3 cfg", v, 16'h8583);
    rd(2'd0, v); check("R3 conv", v, 16'h0000);
    check("R3 pwr_down", {15'd0, pwr_down}, 16'd1);
    check("R3 eng_start", {15'd0, eng_start}, 16'd0);

    // Table walk: single-shot conversions (R1, R2, R4, R5)
    foreach (VEC[i]) begin
      wr(2'd1, 16'h8583);
      check("R4 start", {15'd0, eng_start}, 16'd1);
      check("R4 awake", {15'd0, pwr_down}, 16'd0);
      rd(2'd1, v); check("R4 os_busy", {15'd0, v[15]}, 16'd0);
      done_pulse(VEC[i][31:16]);
      rd(2'd0, v);
      if (VEC[i][32]) check("R2 saturate", v, VEC[i][15:0]);
      else            check("R1 format", v, VEC[i][15:0]);
      rd(2'd1, v); check("R5 os_ready", {15'd0, v[15]}, 16'd1);
      check("R5 sleep", {15'd0, pwr_down}, 16'd1);
    end

    // R10 done while idle ignored (last result 0x8000)
    done_pulse(16'h0007);
    rd(2'd0, v); check("R10 idle_done", v, 16'h8000);
    check("R10 still_idle", {15'd0, pwr_down}, 16'd1);

    // R6 second start while converting
    wr(2'd1, 16'h8583);
    check("R6 first_start", {15'd0, eng_start}, 16'd1);
    wr(2'd1, 16'h8583);
    check("R6 no_restart", {15'd0, eng_start}, 16'd0);
    rd(2'd1, v); check("R6 os_busy", {15'd0, v[15]}, 16'd0);
    done_pulse(16'h0002);
    rd(2'd0, v); check("R6 result", v, 16'h0020);
    check("R6 sleep", {15'd0, pwr_down}, 16'd1);
    check("R6 no_extra_start", {15'd0, eng_start}, 16'd0);
    @(negedge clk);
    check("R6 no_late_start", {15'd0, eng_start}, 16'd0);

    // R7 continuous mode
    wr(2'd1, 16'h0483);
    check("R7 not_yet", {15'd0, eng_start}, 16'd0);
    @(negedge clk);
    check("R7 launch", {15'd0, eng_start}, 16'd1);
    check("R7 awake", {15'd0, pwr_down}, 16'd0);
    done_pulse(16'h0005);
    rd(2'd0, v); check("R7 result", v, 16'h0050);
    check("R7 relaunch", {15'd0, eng_start}, 16'd1);
    rd(2'd1, v); check("R7 os_busy", {15'd0, v[15]}, 16'd0);
    done_pulse(16'hFFFD);
    rd(2'd0, v); check("R7 result2", v, 16'hFFD0);
    check("R7 relaunch2", {15'd0, eng_start}, 16'd1);

    // R8 switch to single-shot mid-conversion
    wr(2'd1, 16'h0583);
    check("R8 still_busy", {15'd0, pwr_down}, 16'd0);
    done_pulse(16'h0009);
    rd(2'd0, v); check("R8 result", v, 16'h0090);
    check("R8 sleep", {15'd0, pwr_down}, 16'd1);
    check("R8 no_start", {15'd0, eng_start}, 16'd0);
    rd(2'd1, v); check("R8 os_ready", {15'd0, v[15]}, 16'd1);

    // R9 general-call reset
    wr(2'd1, 16'h1334);
    rd(2'd1, v); check("R9 cfg_written", v, 16'h9334);
    wr(2'd1, 16'h8583);
    @(negedge clk);
    gc_reset = 1'b1;
    @(negedge clk);
    gc_reset = 1'b0;
    rd(2'd1, v); check("R9 cfg", v, 16'h8583);
    rd(2'd0, v); check("R9 conv", v, 16'h0000);
    check("R9 pwr_down", {15'd0, pwr_down}, 16'd1);
    check("R9 eng_start", {15'd0, eng_start}, 16'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule